// File: doc/BRIEF.md
# Doorbell Mailbox Register File

This block is a small shared register file that sits between a host processor and an on-chip service engine. The two parties swap fixed-size packets through it. Four 64-bit slots carry a command from the host to the engine. Four more carry the answer back. Two doorbell registers tell each side when a packet is ready for it. Each doorbell drives a level interrupt toward the side it alerts.

The host fills the command slots and then sets the message-waiting bit in the engine doorbell. The engine reads the slots, writes its answer into the response slots and sets an event bit in the host doorbell. The host reads the response and then clears its doorbell by writing zero through the AND alias.

Each doorbell has three aliases: an overwrite alias, an AND-mask alias and an OR-mask alias. These let a side set or clear single bits without a read-modify-write. Both sides have a plain register port, with the request and the write enable qualified in the same cycle. These ports are not valid/ready streams. A request is accepted in the cycle it is presented, there is no back-pressure, and read data comes back one cycle later.

Top module: `doorbell_mailbox`

## Requirements
- R1: After reset, all eight data slots and both doorbells read as zero, and `h_irq` and `e_irq` are low.
- R2: Host writes to offsets 0x50 to 0x53 load command slots 0 to 3. Either side reads a slot back on its `*_rdata` one clock after the read request.
- R3: Engine writes to offsets 0x54 to 0x57 load response slots 0 to 3. Either side can read them back.
- R4: A host write to a response slot (0x54 to 0x57) has no effect. An engine write to a command slot (0x50 to 0x53) has no effect.
- R5: Each doorbell has three write aliases, selected by the offset from its base: +0 overwrites, +1 ANDs with the written data, +2 ORs with the written data. The engine doorbell base is 0x60 and the host doorbell base is 0x63. A read through any of the three aliases returns the doorbell value. Either side may use any alias.
- R6: Doorbell bits are numbered MSB-first, so bit 0 is bit 63 of the word. `e_irq` is high exactly when engine-doorbell bit 0 (message waiting, word bit 63) is set. The other bits of the engine doorbell are stored but do not raise `e_irq`.
- R7: `h_irq` is high whenever any bit of the host doorbell is 1. The event bits are, in MSB-first numbering (word bit in brackets):
  - bit 0 (63): response waiting
  - bit 1 (62): message read
  - bit 2 (61): stop-state exit
  - bit 3 (60): engine back from reset
  - bit 4 (59): passthrough request
  - bit 14 (49): timer expiry
- R8: When both sides update the same doorbell in one cycle, the engine's update is applied first and the host's update is applied to that result. So a host AND with zero, or a host overwrite, always decides the final value.
- R9: Writes to unmapped offsets are ignored. Reads of unmapped offsets return zero.
- R10: A read in the same cycle as a write to the same register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write enable (read when low) |
| h_addr | input | 8 | Host word offset |
| h_wdata | input | 64 | Host write data |
| h_rdata | output | 64 | Host read data, valid one cycle after a read request |
| e_req | input | 1 | Engine access request |
| e_we | input | 1 | Engine write enable (read when low) |
| e_addr | input | 8 | Engine word offset |
| e_wdata | input | 64 | Engine write data |
| e_rdata | output | 64 | Engine read data, valid one cycle after a read request |
| h_irq | output | 1 | Level interrupt to the host: host doorbell non-zero |
| e_irq | output | 1 | Level interrupt to the engine: message-waiting bit set |

## Verification
The bench builds the block with its default parameters: 64-bit words, 8-bit offsets and four slots per direction at the offsets listed above. With these values every data slot can be reached, all six doorbell aliases can be used, and the MSB-first event positions fall at word bits 63 down to 49. The directed tests therefore hit the decoder edges at 0x4F, 0x58 and 0x66. They also drive both ports into the same doorbell in the same cycle with every pairing of aliases that R8 depends on.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    DB_NONE = 2'd0,
    DB_PUT  = 2'd1,
    DB_CLR  = 2'd2,
    DB_SET  = 2'd3
  } db_op_e;

  localparam int unsigned MSG_WAIT_BIT   = 0;
  localparam int unsigned EV_RSP_READY   = 0;
  localparam int unsigned EV_MSG_TAKEN   = 1;
  localparam int unsigned EV_STOP_EXIT   = 2;
  localparam int unsigned EV_ENG_RESET   = 3;
  localparam int unsigned EV_PASSTHRU    = 4;
  localparam int unsigned EV_TIMER_FIRED = 14;
endpackage

// File: rtl/mbx_addr_decode.sv
module mbx_addr_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NSLOT     = 4,
  parameter int DATA_BASE = 'h50,
  parameter int EDB_BASE  = 'h60,
  parameter int HDB_BASE  = 'h63,
  localparam int SLOT_W   = $clog2(NSLOT)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_cmd,
  output logic              hit_rsp,
  output logic [SLOT_W-1:0] slot,
  output logic              hit_edb,
  output logic              hit_hdb,
  output db_op_e            op
);
  localparam logic [ADDR_W:0] DLO = (ADDR_W+1)'(DATA_BASE);
  localparam logic [ADDR_W:0] DHI = (ADDR_W+1)'(DATA_BASE + 2*NSLOT);
  localparam logic [ADDR_W:0] ELO = (ADDR_W+1)'(EDB_BASE);
  localparam logic [ADDR_W:0] HLO = (ADDR_W+1)'(HDB_BASE);

  logic [ADDR_W:0] a_ext;
  logic [ADDR_W:0] off;
  logic            in_data;

  assign a_ext   = {1'b0, addr};
  assign off     = a_ext - DLO;
  assign in_data = (a_ext >= DLO) && (a_ext < DHI);
  assign hit_cmd = in_data && !off[SLOT_W];
  assign hit_rsp = in_data &&  off[SLOT_W];
  assign slot    = off[SLOT_W-1:0];

  always_comb begin
    hit_edb = 1'b0;
    hit_hdb = 1'b0;
    op      = DB_NONE;
    for (int k = 0; k < 3; k++) begin
      if (a_ext == ELO + (ADDR_W+1)'(k)) begin
        hit_edb = 1'b1;
        op      = db_op_e'(2'(k + 1));
      end
      if (a_ext == HLO + (ADDR_W+1)'(k)) begin
        hit_hdb = 1'b1;
        op      = db_op_e'(2'(k + 1));
      end
    end
  end
endmodule

// File: rtl/mbx_data_bank.sv
module mbx_data_bank #(
  parameter int W       = 64,
  parameter int N       = 4,
  localparam int SLOT_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        q[i] <= '0;
      else if (we && slot == SLOT_W'(i))
        q[i] <= wdata;
    end
  end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  db_op_e       e_op,
  input  logic [W-1:0] e_data,
  input  db_op_e       h_op,
  input  logic [W-1:0] h_data,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] apply(input logic [W-1:0] cur,
                                         input db_op_e op,
                                         input logic [W-1:0] d);
    case (op)
      DB_PUT:  return d;
      DB_CLR:  return cur & d;
      DB_SET:  return cur | d;
      default: return cur;
    endcase
  endfunction

  logic [W-1:0] after_eng;
  assign after_eng = apply(q, e_op, e_data);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= apply(after_eng, h_op, h_data);
  end
endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 8,
  parameter int NSLOT     = 4,
  parameter int DATA_BASE = 'h50,
  parameter int EDB_BASE  = 'h60,
  parameter int HDB_BASE  = 'h63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              e_req,
  input  logic              e_we,
  input  logic [ADDR_W-1:0] e_addr,
  input  logic [DATA_W-1:0] e_wdata,
  output logic [DATA_W-1:0] e_rdata,
  output logic              h_irq,
  output logic              e_irq
);
  localparam int SLOT_W = $clog2(NSLOT);

  logic              h_cmd, h_rsp, h_edb, h_hdb;
  logic              e_cmd, e_rsp, e_edb, e_hdb;
  logic [SLOT_W-1:0] h_slot, e_slot;
  db_op_e            h_op, e_op;

  mbx_addr_decode #(.ADDR_W(ADDR_W), .NSLOT(NSLOT), .DATA_BASE(DATA_BASE),
                    .EDB_BASE(EDB_BASE), .HDB_BASE(HDB_BASE)) h_dec_i (
    .addr(h_addr), .hit_cmd(h_cmd), .hit_rsp(h_rsp), .slot(h_slot),
    .hit_edb(h_edb), .hit_hdb(h_hdb), .op(h_op));

  mbx_addr_decode #(.ADDR_W(ADDR_W), .NSLOT(NSLOT), .DATA_BASE(DATA_BASE),
                    .EDB_BASE(EDB_BASE), .HDB_BASE(HDB_BASE)) e_dec_i (
    .addr(e_addr), .hit_cmd(e_cmd), .hit_rsp(e_rsp), .slot(e_slot),
    .hit_edb(e_edb), .hit_hdb(e_hdb), .op(e_op));

  logic h_wr, e_wr, h_rd, e_rd;
  assign h_wr = h_req &&  h_we;
  assign e_wr = e_req &&  e_we;
  assign h_rd = h_req && !h_we;
  assign e_rd = e_req && !e_we;

  logic [NSLOT-1:0][DATA_W-1:0] cmd_q, rsp_q;

  mbx_data_bank #(.W(DATA_W), .N(NSLOT)) cmd_bank_i (
    .clk(clk), .rst_n(rst_n), .we(h_wr && h_cmd), .slot(h_slot),
    .wdata(h_wdata), .q(cmd_q));

  mbx_data_bank #(.W(DATA_W), .N(NSLOT)) rsp_bank_i (
    .clk(clk), .rst_n(rst_n), .we(e_wr && e_rsp), .slot(e_slot),
    .wdata(e_wdata), .q(rsp_q));

  logic [DATA_W-1:0] edb_q, hdb_q;

  mbx_doorbell #(.W(DATA_W)) edb_i (
    .clk(clk), .rst_n(rst_n),
    .e_op((e_wr && e_edb) ? e_op : DB_NONE), .e_data(e_wdata),
    .h_op((h_wr && h_edb) ? h_op : DB_NONE), .h_data(h_wdata),
    .q(edb_q));

  mbx_doorbell #(.W(DATA_W)) hdb_i (
    .clk(clk), .rst_n(rst_n),
    .e_op((e_wr && e_hdb) ? e_op : DB_NONE), .e_data(e_wdata),
    .h_op((h_wr && h_hdb) ? h_op : DB_NONE), .h_data(h_wdata),
    .q(hdb_q));

  function automatic logic [DATA_W-1:0] rd_mux(
      input logic c, input logic r, input logic [SLOT_W-1:0] s,
      input logic ed, input logic hd,
      input logic [NSLOT-1:0][DATA_W-1:0] cq,
      input logic [NSLOT-1:0][DATA_W-1:0] rq,
      input logic [DATA_W-1:0] eq, input logic [DATA_W-1:0] hq);
    if (c)  return cq[s];
    if (r)  return rq[s];
    if (ed) return eq;
    if (hd) return hq;
    return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rdata <= '0;
      e_rdata <= '0;
    end else begin
      if (h_rd)
        h_rdata <= rd_mux(h_cmd, h_rsp, h_slot, h_edb, h_hdb, cmd_q, rsp_q, edb_q, hdb_q);
      if (e_rd)
        e_rdata <= rd_mux(e_cmd, e_rsp, e_slot, e_edb, e_hdb, cmd_q, rsp_q, edb_q, hdb_q);
    end
  end

  assign e_irq = edb_q[DATA_W-1-MSG_WAIT_BIT];
  assign h_irq = |hdb_q;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 8,
  parameter int NSLOT     = 4,
  parameter int DATA_BASE = 'h50,
  parameter int EDB_BASE  = 'h60,
  parameter int HDB_BASE  = 'h63
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         h_req,
  input logic                         h_we,
  input logic [ADDR_W-1:0]            h_addr,
  input logic [DATA_W-1:0]            h_wdata,
  input logic                         e_req,
  input logic                         e_we,
  input logic [ADDR_W-1:0]            e_addr,
  input logic [DATA_W-1:0]            e_wdata,
  input logic                         h_irq,
  input logic                         e_irq,
  input logic [NSLOT-1:0][DATA_W-1:0] cmd_q,
  input logic [NSLOT-1:0][DATA_W-1:0] rsp_q
);
  localparam logic [ADDR_W-1:0] CLO  = ADDR_W'(DATA_BASE);
  localparam logic [ADDR_W-1:0] CHI  = ADDR_W'(DATA_BASE + NSLOT - 1);
  localparam logic [ADDR_W-1:0] RLO  = ADDR_W'(DATA_BASE + NSLOT);
  localparam logic [ADDR_W-1:0] RHI  = ADDR_W'(DATA_BASE + 2*NSLOT - 1);
  localparam logic [ADDR_W-1:0] E_RW = ADDR_W'(EDB_BASE);
  localparam logic [ADDR_W-1:0] E_OR = ADDR_W'(EDB_BASE + 2);
  localparam logic [ADDR_W-1:0] H_AN = ADDR_W'(HDB_BASE + 1);
  localparam logic [ADDR_W-1:0] H_OR = ADDR_W'(HDB_BASE + 2);
  localparam logic [ADDR_W-1:0] HLO  = ADDR_W'(HDB_BASE);

  logic h_wr, e_wr, h_data_wr, e_data_wr, h_touch_hdb, e_touch_edb;
  assign h_wr        = h_req && h_we;
  assign e_wr        = e_req && e_we;
  assign h_data_wr   = h_wr && h_addr >= CLO && h_addr <= RHI;
  assign e_data_wr   = e_wr && e_addr >= CLO && e_addr <= RHI;
  assign h_touch_hdb = h_wr && h_addr >= HLO && h_addr <= H_OR;
  assign e_touch_edb = e_wr && e_addr >= E_RW && e_addr <= E_OR;

  // R4: host writes into the response slots leave them unchanged
  a_r4_rsp_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr >= RLO && h_addr <= RHI && !e_data_wr) |=> $stable(rsp_q));

  // R4: engine writes into the command slots leave them unchanged
  a_r4_cmd_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (e_wr && e_addr >= CLO && e_addr <= CHI && !h_data_wr) |=> $stable(cmd_q));

  // R7: an engine OR of a non-zero mask into the host doorbell raises h_irq
  a_r7_host_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (e_wr && e_addr == H_OR && e_wdata != '0 && !h_touch_hdb) |=> h_irq);

  // R6: a host OR of the message-waiting bit raises e_irq
  a_r6_eng_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == E_OR && h_wdata[DATA_W-1] && !e_touch_edb) |=> e_irq);

  // R5, R8: a host AND with zero clears the host doorbell whatever the engine does
  a_r8_host_and_last: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == H_AN && h_wdata == '0) |=> !h_irq);

  // R8: a host overwrite of the engine doorbell wins over a same-cycle engine OR
  a_r8_host_put_last: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == E_RW && !h_wdata[DATA_W-1]) |=> !e_irq);
endmodule

bind doorbell_mailbox mbx_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NSLOT(NSLOT),
  .DATA_BASE(DATA_BASE), .EDB_BASE(EDB_BASE), .HDB_BASE(HDB_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
  .e_req(e_req), .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata),
  .h_irq(h_irq), .e_irq(e_irq), .cmd_q(cmd_q), .rsp_q(rsp_q)
);

// File: tb/doorbell_mailbox_tb.sv
module doorbell_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 0, h_we = 0, e_req = 0, e_we = 0;
  logic [7:0]  h_addr = '0, e_addr = '0;
  logic [63:0] h_wdata = '0, e_wdata = '0;
  logic [63:0] h_rdata, e_rdata;
  logic        h_irq, e_irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  doorbell_mailbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .e_req(e_req), .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata), .e_rdata(e_rdata),
    .h_irq(h_irq), .e_irq(e_irq));

  function automatic logic [63:0] mb(input int k);
    return 64'h1 << (63 - k);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive both ports at a falling edge, release after the next one.
  task automatic cyc(input logic hr, input logic hw, input logic [7:0] ha, input logic [63:0] hd,
                     input logic er, input logic ew, input logic [7:0] ea, input logic [63:0] ed);
    h_req = hr; h_we = hw; h_addr = ha; h_wdata = hd;
    e_req = er; e_we = ew; e_addr = ea; e_wdata = ed;
    @(posedge clk);
    @(negedge clk);
    h_req = 0; h_we = 0; e_req = 0; e_we = 0;
  endtask

  task automatic hwr(input logic [7:0] a, input logic [63:0] d); cyc(1,1,a,d, 0,0,0,0); endtask
  task automatic ewr(input logic [7:0] a, input logic [63:0] d); cyc(0,0,0,0, 1,1,a,d); endtask
  task automatic hrd(input logic [7:0] a, output logic [63:0] d); cyc(1,0,a,0, 0,0,0,0); d = h_rdata; endtask
  task automatic erd(input logic [7:0] a, output logic [63:0] d); cyc(0,0,0,0, 1,0,a,0); d = e_rdata; endtask

  task automatic t_reset;
    logic [63:0] v;
    chk("R1 h_irq", {63'b0, h_irq}, 64'd0);
    chk("R1 e_irq", {63'b0, e_irq}, 64'd0);
    for (int a = 'h50; a <= 'h65; a++) begin
      hrd(8'(a), v);
      chk("R1 reset value", v, 64'd0);
    end
  endtask

  task automatic t_cmd_path;
    logic [63:0] v;
    for (int i = 0; i < 4; i++) hwr(8'('h50 + i), 64'hC0DE_0000_0000_0000 | 64'(i * 3 + 1));
    for (int i = 0; i < 4; i++) begin
      erd(8'('h50 + i), v);
      chk("R2 engine reads command", v, 64'hC0DE_0000_0000_0000 | 64'(i * 3 + 1));
    end
    hrd(8'h53, v);
    chk("R2 host reads command", v, 64'hC0DE_0000_0000_000A);
  endtask

  task automatic t_rsp_path;
    logic [63:0] v;
    for (int i = 0; i < 4; i++) ewr(8'('h54 + i), ~64'(i));
    for (int i = 0; i < 4; i++) begin
      hrd(8'('h54 + i), v);
      chk("R3 host reads response", v, ~64'(i));
    end
    erd(8'h56, v);
    chk("R3 engine reads response", v, ~64'd2);
  endtask

  task automatic t_ignored;
    logic [63:0] v;
    hwr(8'h54, 64'h1111_2222_3333_4444);
    erd(8'h54, v);
    chk("R4 host write to response ignored", v, ~64'd0);
    ewr(8'h50, 64'h5555_6666_7777_8888);
    hrd(8'h50, v);
    chk("R4 engine write to command ignored", v, 64'hC0DE_0000_0000_0001);
  endtask

  task automatic t_unmapped;
    logic [63:0] v;
    hwr(8'h58, 64'hDEAD);
    hwr(8'h4F, 64'hBEEF);
    hrd(8'h58, v);
    chk("R9 unmapped 0x58 reads zero", v, 64'd0);
    erd(8'h4F, v);
    chk("R9 unmapped 0x4F reads zero", v, 64'd0);
    hwr(8'h66, 64'hFFFF);
    hrd(8'h66, v);
    chk("R9 unmapped 0x66 reads zero", v, 64'd0);
    chk("R9 no irq from unmapped writes", {62'b0, h_irq, e_irq}, 64'd0);
  endtask

  task automatic t_engine_db;
    logic [63:0] v;
    hwr(8'h62, mb(0));
    chk("R6 e_irq after host OR", {63'b0, e_irq}, 64'd1);
    erd(8'h61, v);
    chk("R5 read via AND alias", v, mb(0));
    ewr(8'h61, ~mb(0));
    chk("R6 e_irq after engine AND clear", {63'b0, e_irq}, 64'd0);
    hwr(8'h60, mb(1) | 64'h5);
    chk("R6 other bits raise no e_irq", {63'b0, e_irq}, 64'd0);
    erd(8'h60, v);
    chk("R5 overwrite stored", v, mb(1) | 64'h5);
    ewr(8'h62, mb(0));
    hrd(8'h62, v);
    chk("R5 OR keeps old bits", v, mb(0) | mb(1) | 64'h5);
    chk("R6 e_irq set", {63'b0, e_irq}, 64'd1);
    hwr(8'h60, 64'd0);
  endtask

  task automatic t_host_db;
    logic [63:0] v;
    int ev[6] = '{0, 1, 2, 3, 4, 14};
    for (int i = 0; i < 6; i++) begin
      ewr(8'h65, mb(ev[i]));
      chk("R7 h_irq on event bit", {63'b0, h_irq}, 64'd1);
      hrd(8'h63, v);
      chk("R7 event bit position", v, mb(ev[i]));
      hwr(8'h64, 64'd0);
      chk("R5 AND zero clears host doorbell", {63'b0, h_irq}, 64'd0);
    end
    ewr(8'h63, 64'h1);
    chk("R7 any bit raises h_irq", {63'b0, h_irq}, 64'd1);
    hwr(8'h64, ~64'h1);
    chk("R5 AND mask clears single bit", {63'b0, h_irq}, 64'd0);
  endtask

  task automatic t_order;
    logic [63:0] v;
    cyc(1,1,8'h64,64'd0, 1,1,8'h65,mb(0));
    chk("R8 host AND after engine OR", {63'b0, h_irq}, 64'd0);
    cyc(1,1,8'h65,mb(14), 1,1,8'h65,mb(4));
    hrd(8'h63, v);
    chk("R8 both ORs combine", v, mb(14) | mb(4));
    cyc(1,1,8'h63,mb(2), 1,1,8'h64,64'd0);
    hrd(8'h63, v);
    chk("R8 host overwrite after engine AND", v, mb(2));
    cyc(1,1,8'h60,64'd0, 1,1,8'h62,mb(0));
    chk("R8 host overwrite beats engine OR", {63'b0, e_irq}, 64'd0);
    cyc(1,1,8'h62,mb(0), 1,1,8'h61,64'd0);
    chk("R8 host OR after engine AND", {63'b0, e_irq}, 64'd1);
    hwr(8'h60, 64'd0);
    hwr(8'h63, 64'd0);
  endtask

  task automatic t_read_during_write;
    cyc(1,1,8'h51,64'hAAAA, 1,0,8'h51,0);
    chk("R10 engine read sees old command", e_rdata, 64'hC0DE_0000_0000_0004);
    cyc(1,0,8'h55,0, 1,1,8'h55,64'hBBBB);
    chk("R10 host read sees old response", h_rdata, ~64'd1);
    cyc(1,0,8'h63,0, 1,1,8'h65,mb(3));
    chk("R10 doorbell read sees old value", h_rdata, 64'd0);
    chk("R7 doorbell updated after", {63'b0, h_irq}, 64'd1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd_path();
    t_rsp_path();
    t_ignored();
    t_unmapped();
    t_engine_db();
    t_host_db();
    t_order();
    t_read_during_write();
    finish_run();
  end
endmodule